// File: doc/BRIEF.md
# Refresh Interval Timer

This block produces the timing for periodic DRAM refresh. A 16-bit up-counter runs on a fraction of the system clock. Software picks that fraction from seven divide ratios, or a stop code. The counter value is compared with a software-loaded constant. When the counter reaches the constant, three things follow:

- a status flag is raised;
- an interrupt can be requested;
- if refresh control is on, a one-cycle refresh request is sent to the memory controller.

The counter then returns to zero, so matches recur at a fixed interval.

Software reaches the block through a small register port with three registers:

- control/status (select 0);
- counter (select 1);
- constant (select 2).

Read data is combinational from the current select. The flag can only be cleared in two steps: software first reads the status register while the flag is set, then writes a 0 to the flag bit.

Top module: `refresh_interval_timer`

## Requirements
- R1: After reset the counter, the constant and the whole status register read 0, and both `irq` and `refresh_req` are low.
- R2: Status bit 6 (match flag) becomes 1 on the clock edge after the cycle in which the counter equals the constant. It is not raised while both registers still hold their untouched reset zeros. They stop being untouched once either register has been written or the counter has advanced.
- R3: On the clock edge that raises the flag, the counter is reloaded with 0. With constant C and no writes, matches therefore recur every C+1 counter steps.
- R4: The flag clears only when a write to select 0 with bit 6 = 0 follows an earlier read of select 0 made while the flag was 1. A write without such a read leaves the flag at 1. A new match on the same edge as a clearing write wins, and the flag stays 1.
- R5: `irq` is high exactly while the flag and status bit 5 (interrupt enable) are both 1. Bit 5 resets to 0.
- R6: Status bits 4..2 select the count rate. The counter advances once per N system clocks for these codes:

  | Code | N |
  |---|---|
  | 001 | 2 |
  | 010 | 8 |
  | 011 | 32 |
  | 100 | 128 |
  | 101 | 512 |
  | 110 | 2048 |
  | 111 | 4096 |

  Code 000, the reset value, holds the counter.
- R7: With status bit 1 = 1, each match produces a single one-cycle `refresh_req` pulse, on the same edge that raises the flag, whatever bit 5 holds. With bit 1 = 0 there is no pulse.
- R8: A write to the counter overrides an increment in the same cycle. The written value is the one compared, so writing the constant's value causes a match.
- R9: Status bits 15..7 and bit 0 always read 0. A write cannot set the flag.
- R10: Select 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 status, 1 counter, 2 constant, 3 unused |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; a status read while the flag is set arms the clear |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Compare-match interrupt request |
| refresh_req | output | 1 | One-cycle refresh request per match |

## Verification
Two functions can fall on the same edge:

- a compare match that raises the flag, and a software write of 0 that would clear it;
- a software write to the counter, and a prescaler step.

The bench provokes the first case with the clock stopped. It reads the set flag, then writes the counter to the constant's value. In the very next cycle it writes the clear, so the match and the clear land together. The flag must read 1 afterwards. The second case is provoked by writing the counter while the fastest rate is running. A behavioural model predicts every cycle's outputs and judges both cases cycle by cycle.

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq,
  output logic             refresh_req
);

  localparam logic [1:0] SEL_CSR = 2'd0;
  localparam logic [1:0] SEL_CNT = 2'd1;
  localparam logic [1:0] SEL_COR = 2'd2;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q, cor_q;
  logic [2:0]       rate_q;
  logic             flag_q, ien_q, rfen_q;
  logic             armed_q, rd_seen_q, hit_d_q;

  function automatic logic [DIV_W-1:0] tap_mask(input logic [2:0] code);
    int bits;
    case (code)
      3'd1: bits = 1;
      3'd2: bits = 3;
      3'd3: bits = 5;
      3'd4: bits = 7;
      3'd5: bits = 9;
      3'd6: bits = 11;
      default: bits = 12;
    endcase
    if (bits > DIV_W) bits = DIV_W;
    return DIV_W'((64'd1 << bits) - 64'd1);
  endfunction

  logic wr_csr, wr_cnt, wr_cor, rd_csr, tick, hit, hit_evt, clr_ok;

  assign wr_csr  = wr_en && reg_sel == SEL_CSR;
  assign wr_cnt  = wr_en && reg_sel == SEL_CNT;
  assign wr_cor  = wr_en && reg_sel == SEL_COR;
  assign rd_csr  = rd_en && reg_sel == SEL_CSR;
  assign tick    = (rate_q != 3'd0) && (&(div_q | ~tap_mask(rate_q)));
  assign hit     = armed_q && (cnt_q == cor_q);
  assign hit_evt = hit && !hit_d_q;
  assign clr_ok  = wr_csr && !wdata[6] && rd_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q       <= '0;
      cnt_q       <= '0;
      cor_q       <= '0;
      rate_q      <= 3'd0;
      flag_q      <= 1'b0;
      ien_q       <= 1'b0;
      rfen_q      <= 1'b0;
      armed_q     <= 1'b0;
      rd_seen_q   <= 1'b0;
      hit_d_q     <= 1'b0;
      refresh_req <= 1'b0;
    end else begin
      div_q       <= div_q + 1'b1;
      hit_d_q     <= hit;
      refresh_req <= hit_evt && rfen_q;
      armed_q     <= armed_q || wr_cnt || wr_cor || tick;

      if (wr_cnt)       cnt_q <= wdata;
      else if (hit_evt) cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + 1'b1;

      if (wr_cor) cor_q <= wdata;

      if (wr_csr) begin
        ien_q  <= wdata[5];
        rate_q <= wdata[4:2];
        rfen_q <= wdata[1];
      end

      if (hit_evt)     flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;

      if (clr_ok)                rd_seen_q <= 1'b0;
      else if (rd_csr && flag_q) rd_seen_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CSR: rdata = {{(CNT_W-7){1'b0}}, flag_q, ien_q, rate_q, rfen_q, 1'b0};
      SEL_CNT: rdata = cnt_q;
      SEL_COR: rdata = cor_q;
      default: rdata = '0;
    endcase
  end

  assign irq = flag_q && ien_q;

  assert_flag_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> flag_q);

  assert_cnt_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && !wr_cnt) |=> (cnt_q == '0));

  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_seen_q) |=> flag_q);

  assert_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 3'd0 && !wr_cnt && !hit_evt) |=> $stable(cnt_q));

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);

  assert_req_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> flag_q);

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata)));

endmodule

// File: tb/refresh_interval_timer_bench.sv
module refresh_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq, refresh_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  refresh_interval_timer u_refresh_interval_timer (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .refresh_req(refresh_req)
  );

  // Behavioural reference model
  int m_div, m_cnt, m_cor, m_cks;
  bit m_flag, m_ien, m_rf, m_armed, m_seen, m_hitd, m_req;

  function automatic int ratio(input int code);
    case (code)
      1: return 2;     2: return 8;     3: return 32;    4: return 128;
      5: return 512;   6: return 2048;  default: return 4096;
    endcase
  endfunction

  function automatic int model_read(input int sel);
    case (sel)
      0: return (int'(m_flag) << 6) | (int'(m_ien) << 5) | (m_cks << 2) | (int'(m_rf) << 1);
      1: return m_cnt;
      2: return m_cor;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_cor = 0; m_cks = 0;
      m_flag = 0; m_ien = 0; m_rf = 0; m_armed = 0; m_seen = 0; m_hitd = 0; m_req = 0;
    end else begin
      bit tk, hit, evt, ws, wc, wo, rs, clr;
      tk  = (m_cks != 0) && ((m_div % ratio(m_cks)) == ratio(m_cks) - 1);
      hit = m_armed && (m_cnt == m_cor);
      evt = hit && !m_hitd;
      ws  = wr_en && reg_sel == 0;
      wc  = wr_en && reg_sel == 1;
      wo  = wr_en && reg_sel == 2;
      rs  = rd_en && reg_sel == 0;
      clr = ws && !wdata[6] && m_seen;
      m_req = evt && m_rf;
      if (clr) m_seen = 0; else if (rs && m_flag) m_seen = 1;
      if (evt) m_flag = 1; else if (clr) m_flag = 0;
      if (wc) m_cnt = wdata; else if (evt) m_cnt = 0; else if (tk) m_cnt = (m_cnt + 1) % 65536;
      if (wo) m_cor = wdata;
      m_armed = m_armed || wc || wo || tk;
      m_hitd = hit;
      if (ws) begin m_ien = wdata[5]; m_cks = wdata[4:2]; m_rf = wdata[1]; end
      m_div = (m_div + 1) % 4096;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdata == 16'(model_read(reg_sel)),
          reg_sel == 0 ? "R2 status" : reg_sel == 1 ? "R8 counter" : reg_sel == 2 ? "R3 constant" : "R10 unused",
          rdata, model_read(reg_sel));
      chk(irq == (m_flag && m_ien), "R5 irq", irq, m_flag && m_ien);
      chk(refresh_req == m_req, "R7 refresh_req", refresh_req, m_req);
    end
  end

  task automatic drive(input int sel, input bit w, input bit r, input int d);
    @(posedge clk); #1;
    reg_sel = 2'(sel); wr_en = w; rd_en = r; wdata = 16'(d);
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic peek(input int sel, output int v);
    @(posedge clk); #1;
    reg_sel = 2'(sel);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int v;
    idle(3);
    rst_n = 1'b1;
    // R1: reset state
    for (int s = 0; s < 3; s++) begin
      peek(s, v);
      chk(v == 0, "R1 reset value", v, 0);
    end
    chk(irq == 0 && refresh_req == 0, "R1 outputs", {irq, refresh_req}, 0);
    // R2: untouched zeros never flag
    idle(50);
    peek(0, v);
    chk(v[6] == 0, "R2 no flag on reset zeros", v[6], 0);
    // R6/R7: rate /2 with refresh on, constant 5
    drive(2, 1, 0, 5);
    drive(0, 1, 0, 16'h0006);
    idle(60);
    peek(0, v);
    chk(v[6] == 1, "R2 flag set by match", v[6], 1);
    // R4: write 0 without prior read keeps the flag
    drive(0, 1, 0, 16'h0006);
    peek(0, v);
    chk(v[6] == 1, "R4 flag kept without read", v[6], 1);
    // R4: read then write 0 clears it (rate stopped)
    drive(0, 1, 1, 16'h0000);
    drive(0, 0, 1, 0);
    drive(0, 1, 0, 16'h0000);
    peek(0, v);
    chk(v[6] == 0, "R4 flag cleared after read", v[6], 0);
    // R5 and R8: interrupt enabled, counter written to the constant's value
    drive(0, 1, 0, 16'h0020);
    drive(1, 1, 0, 5);
    idle(2);
    chk(irq == 1, "R5 irq with enable", irq, 1);
    // R4 concurrency: clear lands on the same edge as a new match
    drive(1, 1, 0, 1);
    drive(0, 0, 1, 0);
    @(posedge clk); #1; reg_sel = 2'd1; wr_en = 1'b1; wdata = 16'd5;
    @(posedge clk); #1; reg_sel = 2'd0; wdata = 16'h0020;
    @(posedge clk); #1; wr_en = 1'b0;
    peek(0, v);
    chk(v[6] == 1, "R4 match wins over clear", v[6], 1);
    // R8: counter writes while the fastest rate runs
    drive(2, 1, 0, 16'h0100);
    drive(0, 1, 0, 16'h0006);
    for (int i = 0; i < 20; i++) drive(1, 1, 0, 16'h00F0 + i);
    idle(40);
    // R6: every rate code
    drive(2, 1, 0, 16'hFFFF);
    for (int c = 1; c < 8; c++) begin
      drive(1, 1, 0, 0);
      drive(0, 1, 0, (c << 2) | 2);
      idle(ratio(c) * 2 + 7);
    end
    drive(0, 1, 0, 0);
    peek(1, v);
    idle(30);
    begin
      int v2;
      peek(1, v2);
      chk(v2 == v, "R6 code 000 holds counter", v2, v);
    end
    // R9: reserved bits and flag not writable
    drive(0, 1, 1, 0);
    drive(0, 1, 0, 0);
    drive(0, 1, 0, 16'hFFFF);
    peek(0, v);
    chk((v & 16'hFF81) == 0, "R9 reserved bits read 0", v & 16'hFF81, 0);
    chk(v[6] == 0, "R9 write cannot set flag", v[6], 0);
    drive(0, 1, 0, 0);
    // R10: unused select
    drive(3, 1, 0, 16'h1234);
    peek(3, v);
    chk(v == 0, "R10 unused select reads 0", v, 0);
    peek(2, v);
    chk(v == 16'hFFFF, "R10 write to select 3 ignored", v, 16'hFFFF);
    // R3: periodic matches with constant 3 at /2
    drive(2, 1, 0, 3);
    drive(1, 1, 0, 0);
    drive(0, 1, 0, 16'h0006);
    idle(100);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule